// File: doc/BRIEF.md
# Multithreaded Register Rename Unit

This block renames register operands for up to four hardware threads that share one pool of physical registers. Each thread has its own table that maps its logical registers to physical ones. Because the tables are separate, the same logical name used by two threads resolves to two different physical registers. A thread becomes active simply by issuing with its thread ID. No context has to be switched in first.

Each cycle the unit can accept one instruction, tagged with a thread ID. The instruction names two source registers and one destination register. The unit looks up both sources in the issuing thread's table and returns their physical tags. It takes a fresh physical register from a shared free pool for the destination. It also returns the physical register that the destination mapped to before, so that commit can later hand that register back through the free port. When the pool is empty, the unit stalls the instruction and leaves all of its state untouched.

Top module: `smt_rename`

## Requirements
- R1: After reset, logical register i of thread t maps to physical register t*16+i. Physical registers 64 to 127 start in the free pool.
- R2: `ren_psrc1` and `ren_psrc2` give the current mapping of `ren_src1` and `ren_src2` in thread `ren_tid`. A source that names the same register as the destination reads the mapping from before the instruction.
- R3: An accepted instruction gets the lowest-numbered free physical register on `ren_pdst`, and that register leaves the pool. `ren_pold` gives the destination's previous mapping. Later instructions of the same thread read the new mapping.
- R4: Renaming in one thread never changes the mapping of any other thread.
- R5: When `ren_valid` is high and the pool is empty, `ren_stall` is 1 and `ren_ok` is 0, and no map or pool state changes.
- R6: When `free_valid` is high, register `free_preg` returns to the pool and can be allocated from the next cycle on.
- R7: While `ren_valid` is low, no mapping changes and no register leaves the pool. The source lookup outputs still show the current mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction present this cycle |
| ren_tid | input | 2 | Thread ID |
| ren_src1 | input | 4 | Logical source 1 |
| ren_src2 | input | 4 | Logical source 2 |
| ren_dst | input | 4 | Logical destination |
| ren_stall | output | 1 | Instruction refused, pool empty |
| ren_ok | output | 1 | Instruction accepted this cycle |
| ren_psrc1 | output | 7 | Physical tag of source 1 |
| ren_psrc2 | output | 7 | Physical tag of source 2 |
| ren_pdst | output | 7 | Newly allocated physical destination |
| ren_pold | output | 7 | Previous physical mapping of the destination |
| free_valid | input | 1 | Return a physical register to the pool |
| free_preg | input | 7 | Register being returned |

## Verification
The assertions assume that `free_preg` never names a register that is already in the pool, and that a register is returned only after it has appeared on `ren_pold`. The stimulus respects both by keeping a queue of the `ren_pold` values from accepted instructions and freeing only entries popped from that queue, so no register is returned twice. A behavioural model in the bench tracks every thread's map and the pool, and its outputs are compared against the design on every cycle. The stimulus includes a phase that drains the pool until the unit stalls, followed by a single return.

// File: rtl/smt_rename.sv
module smt_rename #(
  parameter int NT = 4,
  parameter int NL = 16,
  parameter int NP = 128,
  localparam int TW = $clog2(NT),
  localparam int LW = $clog2(NL),
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [TW-1:0] ren_tid,
  input  logic [LW-1:0] ren_src1,
  input  logic [LW-1:0] ren_src2,
  input  logic [LW-1:0] ren_dst,
  output logic          ren_stall,
  output logic          ren_ok,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_psrc2,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          free_valid,
  input  logic [PW-1:0] free_preg
);
  localparam int NPRE = NT * NL;

  logic [PW-1:0] map_q [NT][NL];
  logic [NP-1:0] free_q, free_nxt;
  logic [PW-1:0] alloc;
  logic          has_free;

  always_comb begin
    has_free = 1'b0;
    alloc = '0;
    for (int i = NP - 1; i >= 0; i--)
      if (free_q[i]) begin
        has_free = 1'b1;
        alloc = PW'(i);
      end
  end

  assign ren_stall = ren_valid & ~has_free;
  assign ren_ok    = ren_valid & has_free;
  assign ren_psrc1 = map_q[ren_tid][ren_src1];
  assign ren_psrc2 = map_q[ren_tid][ren_src2];
  assign ren_pold  = map_q[ren_tid][ren_dst];
  assign ren_pdst  = alloc;

  always_comb begin
    free_nxt = free_q;
    if (ren_ok) free_nxt[alloc] = 1'b0;
    if (free_valid) free_nxt[free_preg] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++)
        for (int i = 0; i < NL; i++)
          map_q[t][i] <= PW'(t * NL + i);
      for (int p = 0; p < NP; p++)
        free_q[p] <= (p >= NPRE);
    end else begin
      if (ren_ok) map_q[ren_tid][ren_dst] <= alloc;
      free_q <= free_nxt;
    end
  end
endmodule

module smt_rename_chk #(
  parameter int NP = 128,
  localparam int PW = $clog2(NP)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_stall,
  input logic          ren_ok,
  input logic [PW-1:0] ren_pdst,
  input logic [PW-1:0] ren_pold,
  input logic          free_valid,
  input logic [PW-1:0] free_preg,
  input logic [NP-1:0] free_vec
);
  p_alloc_was_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> free_vec[ren_pdst]);
  p_alloc_leaves_pool_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok && !(free_valid && free_preg == ren_pdst) |=> !free_vec[$past(ren_pdst)]);
  p_old_not_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> ren_pold != ren_pdst);
  p_stall_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |-> !ren_ok && ren_valid);
  p_stall_holds_pool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall && !free_valid |=> $stable(free_vec));
  p_free_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> free_vec[$past(free_preg)]);
  p_idle_holds_pool_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_valid && !free_valid |=> $stable(free_vec));
endmodule

bind smt_rename smt_rename_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_stall(ren_stall),
  .ren_ok(ren_ok), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
  .free_valid(free_valid), .free_preg(free_preg), .free_vec(free_q)
);

// File: tb/smt_rename_tb.sv
`timescale 1ns/1ps
module smt_rename_tb;
  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, free_valid = 0;
  logic [1:0] ren_tid = 0;
  logic [3:0] ren_src1 = 0, ren_src2 = 0, ren_dst = 0;
  logic [6:0] free_preg = 0;
  logic ren_stall, ren_ok;
  logic [6:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;

  always #4 clk = ~clk;

  smt_rename u_dut (.*);

  int checks = 0, failures = 0;
  int mmap [4][16];
  bit mfree [128];
  int fq [$];
  int seed = 7;
  bit done = 0;

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, int t, int s1, int s2, int d, bit fv, int fp, string tag);
    int lo;
    bit ok;
    @(negedge clk);
    ren_valid = v; ren_tid = 2'(t); ren_src1 = 4'(s1); ren_src2 = 4'(s2);
    ren_dst = 4'(d); free_valid = fv; free_preg = 7'(fp);
    #2;
    lo = -1;
    for (int i = 127; i >= 0; i--) if (mfree[i]) lo = i;
    ok = v && lo >= 0;
    chk(ren_psrc1, mmap[t][s1], {tag, " R2 psrc1"});
    chk(ren_psrc2, mmap[t][s2], {tag, " R2 psrc2"});
    chk(ren_stall, v && lo < 0, {tag, " R5 stall"});
    chk(ren_ok, ok, {tag, " R7 ok"});
    if (ok) begin
      chk(ren_pdst, lo, {tag, " R3 pdst"});
      chk(ren_pold, mmap[t][d], {tag, " R3 pold"});
      fq.push_back(mmap[t][d]);
      mfree[lo] = 0;
      mmap[t][d] = lo;
    end
    if (fv) mfree[fp] = 1;
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 4; t++) for (int i = 0; i < 16; i++) mmap[t][i] = t * 16 + i;
    for (int p = 0; p < 128; p++) mfree[p] = (p >= 64);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); ren_tid = 2'(t); ren_src1 = 4'(i); ren_src2 = 4'(15 - i); #2;
        chk(ren_psrc1, t * 16 + i, "R1 reset map");
        chk(ren_ok, 0, "R7 idle");
      end

    cyc(1, 0, 3, 5, 3, 0, 0, "R2 self-src");
    chk(ren_psrc1, 3, "R2 old mapping for self source");
    cyc(1, 1, 3, 3, 7, 0, 0, "R4 other thread");
    chk(ren_psrc1, 19, "R4 thread1 r3 untouched");
    cyc(1, 0, 3, 7, 9, 0, 0, "R3 new map");
    chk(ren_psrc1, 64, "R3 thread0 r3 renamed");
    cyc(0, 0, 3, 3, 3, 0, 0, "R7 idle read");
    chk(ren_psrc1, 64, "R7 map held");

    for (int k = 0; k < 400; k++) begin
      int r = rnd();
      bit fv = (fq.size() > 4) && r[0];
      int fp = 0;
      if (fv) fp = fq.pop_front();
      cyc(r[1] | r[2], r[4:3], r[8:5], r[12:9], (r >> 4) & 15, fv, fp, "mix");
    end

    for (int k = 0; k < 80; k++) cyc(1, k % 4, k % 16, (k + 3) % 16, (k * 5) % 16, 0, 0, "drain");
    chk(ren_stall, 1, "R5 pool empty stalls");
    begin
      int fp = fq.pop_front();
      cyc(0, 0, 0, 0, 0, 1, fp, "R6 free");
      cyc(1, 2, 1, 2, 4, 0, 0, "R6 reuse");
      chk(ren_pdst, fp, "R6 freed reg allocated");
    end
    cyc(1, 3, 0, 1, 2, 0, 0, "R5 again");
    chk(ren_stall, 1, "R5 stall after reuse");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule